// File: doc/BRIEF.md
# Cascadable Serial Configuration Bitstream Streamer

This block holds a configuration bitstream in an internal ROM and shifts it out one bit per clock on a serial data output, for loading a programmable logic device. A bit address counter walks the stored image. Each stored byte is sent most significant bit first. The serial output is modelled as a data value plus an output-enable flag, so the block can share a line with other streamers.

Several streamers can be daisy-chained on one data line. When a streamer has sent its last bit, it releases the line and drives its chain-enable output low. That output enables the next device in the chain. An active-low stream reset input clears the counter and holds the line released. An active-low chip-enable input puts the block into standby. In standby the line is released but the counter position is kept.

A configuration command input starts a fixed-width low pulse on an open-drain "start configuration" line. This lets the target device restart configuration without a power cycle. The open-drain line is modelled as a drive-low flag. A synchronous active-low power-on reset input puts the whole block into its initial state.

Top module: `cfg_bitstreamer`

## Requirements
- R1: When por_n=1, rst_oe_n=1, ce_n=0 and the counter is below LEN_BITS, each rising clk edge puts the next stream bit on data_o, raises data_oe and advances the counter by one.
- R2: While rst_oe_n=0, data_oe is 0 in the same cycle, and each edge clears the counter. After rst_oe_n returns to 1, the stream restarts at bit 0.
- R3: Stream bit c is bit (7 - c mod 8) of stored byte c/8. Byte k holds (k*29 + 0x5A) mod 256.
- R4: The first enabled edge after the counter reaches LEN_BITS drives chain_en_n low and data_oe low. chain_en_n then stays low until an edge with rst_oe_n=0 or por_n=0.
- R5: While ce_n=1, data_oe is 0 in the same cycle, whatever rst_oe_n is. The counter holds, and streaming resumes at the following bit when ce_n returns to 0.
- R6: A clock edge that samples cfg_cmd=1 while no pulse is active makes cf_drive_low go to 1 for exactly CF_WIDTH cycles, starting after that edge.
- R7: cfg_cmd=1 during an active pulse is ignored. The pulse neither restarts nor lengthens.
- R8: An edge with por_n=0 clears the counter, sets chain_en_n to 1, sets data_oe to 0 and ends any active CF pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one stream bit per rising edge |
| por_n | input | 1 | Synchronous active-low power-on reset |
| rst_oe_n | input | 1 | Active-low stream reset / output enable |
| ce_n | input | 1 | Active-low chip enable; high selects standby |
| cfg_cmd | input | 1 | Command that starts a configuration pulse |
| data_o | output | 1 | Serial stream data value |
| data_oe | output | 1 | Drive enable for data_o; 0 means high impedance |
| chain_en_n | output | 1 | Active-low enable handed to the next device in the chain |
| cf_drive_low | output | 1 | 1 while the open-drain configuration line is pulled low |

## Verification
The assertions check several rules on every cycle:
- the line is released during standby, during stream reset and after handoff;
- the counter never passes LEN_BITS and never advances at the terminal count;
- the chain-enable output stays low once low until a reset;
- an active CF pulse counts down strictly by one each cycle, so a repeated command cannot restart it.

Only the bench scenarios can show the rest:
- the bit order and byte content of the stream;
- the stream resuming at the correct bit after standby and restarting at bit 0 after a stream reset;
- the exact CF pulse width.

// File: rtl/cfgstrm_pkg.sv
// Package: shared types and the ROM image generator for the bitstream streamer.
// Assumes byte-wide storage; the image is computed, not listed.
package cfgstrm_pkg;
    typedef logic [7:0] byte_t;

    // Image byte for a given index: (k*29 + 0x5A) mod 256
    function automatic byte_t image_byte(input int k);
        return byte_t'((k * 29 + 90) % 256);
    endfunction
endpackage

// File: rtl/cfgstrm_rom.sv
// Module: byte ROM holding the configuration image.
// Assumes BYTES >= 2; reads are combinational; an out-of-range address returns 0.
module cfgstrm_rom
    import cfgstrm_pkg::*;
#(
    parameter int BYTES = 8,
    parameter int AW    = $clog2(BYTES)
) (
    input  logic [AW:0] addr,
    output byte_t       rd
);
    byte_t mem [BYTES];

    // Fill the image at start-up
    initial begin
        for (int k = 0; k < BYTES; k++) mem[k] = image_byte(k);
    end

    // Combinational read with range guard
    always_comb begin
        if (addr < (AW+1)'(BYTES)) rd = mem[addr[AW-1:0]];
        else                       rd = '0;
    end
endmodule

// File: rtl/cfgstrm_counter.sv
// Module: bit address counter with terminal-count flag.
// Assumes the owner never asserts adv at the terminal count; clr wins over adv.
module cfgstrm_counter #(
    parameter int LEN_BITS = 60,
    parameter int CW       = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [CW-1:0] cnt,
    output logic          term
);
    // Count up on adv, clear on reset or clr
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (adv)      cnt <= cnt + 1'b1;
    end

    assign term = (cnt == CW'(LEN_BITS));

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LEN_BITS));
    // R4
    no_adv_at_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term |-> !adv);
    // R2
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/cfgstrm_cfpulse.sv
// Module: fixed-width pulse generator for the open-drain configuration line.
// Assumes CF_WIDTH >= 1; a command while the pulse is running is dropped.
module cfgstrm_cfpulse #(
    parameter int CF_WIDTH = 4,
    parameter int PW       = $clog2(CF_WIDTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd,
    output logic drive_low
);
    logic [PW-1:0] left_q;

    // Load the width on an idle command, then count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)                      left_q <= '0;
        else if (left_q != '0)           left_q <= left_q - PW'(1);
        else if (cmd)                    left_q <= PW'(CF_WIDTH);
    end

    assign drive_low = (left_q != '0);

    // R7
    cf_no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (left_q != '0) |=> (left_q == $past(left_q) - PW'(1)));
    // R6
    cf_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd && left_q == '0) |=> (left_q == PW'(CF_WIDTH)));
endmodule

// File: rtl/cfg_bitstreamer.sv
// Module: top of the cascadable serial bitstream streamer.
// Shifts ROM bits MSB-first while enabled, hands off to the next device at the
// end of the image, and releases the data line in reset, standby and after handoff.
// Assumes LEN_BITS <= 8*BYTES and BYTES >= 2; all resets are synchronous.
module cfg_bitstreamer #(
    parameter int BYTES    = 8,
    parameter int LEN_BITS = 60,
    parameter int CF_WIDTH = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_oe_n,
    input  logic ce_n,
    input  logic cfg_cmd,
    output logic data_o,
    output logic data_oe,
    output logic chain_en_n,
    output logic cf_drive_low
);
    import cfgstrm_pkg::*;

    localparam int AW = $clog2(BYTES);
    localparam int CW = AW + 4;

    logic          run;
    logic          term;
    logic          adv;
    logic [CW-1:0] cnt;
    byte_t         rom_byte;
    logic          cur_bit;
    logic          dq, oe_q, ceo_q;

    assign run = rst_oe_n && !ce_n;
    assign adv = por_n && run && !term;

    cfgstrm_counter #(.LEN_BITS(LEN_BITS), .CW(CW)) u_cnt (
        .clk(clk), .rst_n(por_n), .clr(!rst_oe_n), .adv(adv),
        .cnt(cnt), .term(term)
    );

    cfgstrm_rom #(.BYTES(BYTES), .AW(AW)) u_rom (
        .addr(cnt[CW-1:3]), .rd(rom_byte)
    );

    // Pick the current bit, MSB first within the byte
    always_comb cur_bit = rom_byte[3'd7 - cnt[2:0]];

    // Output data, drive flag and chain-enable sequencing
    always_ff @(posedge clk) begin
        if (!por_n || !rst_oe_n) begin
            dq    <= 1'b0;
            oe_q  <= 1'b0;
            ceo_q <= 1'b1;
        end else if (run) begin
            if (!term) begin
                dq   <= cur_bit;
                oe_q <= 1'b1;
            end else begin
                oe_q  <= 1'b0;
                ceo_q <= 1'b0;
            end
        end else begin
            oe_q <= 1'b0;
        end
    end

    assign data_o     = dq;
    assign data_oe    = oe_q && run;
    assign chain_en_n = ceo_q;

    cfgstrm_cfpulse #(.CF_WIDTH(CF_WIDTH)) u_cf (
        .clk(clk), .rst_n(por_n), .cmd(cfg_cmd), .drive_low(cf_drive_low)
    );

    // R5
    standby_hiz_chk: assert property (@(posedge clk) disable iff (!por_n)
        ce_n |-> !data_oe);
    // R2
    reset_hiz_chk: assert property (@(posedge clk) disable iff (!por_n)
        !rst_oe_n |-> !data_oe);
    // R4
    handoff_release_chk: assert property (@(posedge clk) disable iff (!por_n)
        !chain_en_n |-> !data_oe);
    // R4
    handoff_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!chain_en_n && rst_oe_n) |=> !chain_en_n);
    // R8
    por_clear_chk: assert property (@(posedge clk)
        !por_n |=> (chain_en_n && !data_oe && !cf_drive_low));
endmodule

// File: tb/cfg_bitstreamer_tb.sv
module cfg_bitstreamer_tb;
    localparam int CLK_P    = 10;
    localparam int BYTES    = 8;
    localparam int LEN_BITS = 60;
    localparam int CF_WIDTH = 4;

    logic clk = 1'b0;
    logic por_n = 1'b0, rst_oe_n = 1'b0, ce_n = 1'b1, cfg_cmd = 1'b0;
    logic data_o, data_oe, chain_en_n, cf_drive_low;

    int checks = 0;
    int errors = 0;

    // reference model state
    int m_cnt = 0, m_cf = 0;
    logic m_oe = 0, m_dq = 0, m_ceo = 1;

    always #(CLK_P/2) clk = ~clk;

    cfg_bitstreamer #(.BYTES(BYTES), .LEN_BITS(LEN_BITS), .CF_WIDTH(CF_WIDTH)) u_dut (
        .clk(clk), .por_n(por_n), .rst_oe_n(rst_oe_n), .ce_n(ce_n), .cfg_cmd(cfg_cmd),
        .data_o(data_o), .data_oe(data_oe), .chain_en_n(chain_en_n),
        .cf_drive_low(cf_drive_low)
    );

    // R3: expected stream bit from the stated image formula
    function automatic logic exp_bit(input int c);
        int b;
        b = ((c / 8) * 29 + 90) % 256;
        return logic'((b >> (7 - (c % 8))) & 1);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update for one edge, using the inputs sampled at that edge
    task automatic model_edge();
        if (!por_n || !rst_oe_n) begin
            m_cnt = 0; m_oe = 0; m_dq = 0; m_ceo = 1;
        end else if (!ce_n) begin
            if (m_cnt < LEN_BITS) begin
                m_dq = exp_bit(m_cnt); m_oe = 1; m_cnt++;
            end else begin
                m_oe = 0; m_ceo = 0;
            end
        end else begin
            m_oe = 0;
        end
        if (!por_n)                  m_cf = 0;
        else if (m_cf != 0)          m_cf--;
        else if (cfg_cmd)            m_cf = CF_WIDTH;
    endtask

    // One cycle: drive at negedge, edge, compare at the next negedge
    task automatic tick(input logic p, input logic r, input logic c, input logic cmd);
        logic e_oe;
        string t;
        por_n = p; rst_oe_n = r; ce_n = c; cfg_cmd = cmd;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        e_oe = m_oe && rst_oe_n && !ce_n;
        if (ce_n)           t = "R5 standby release";
        else if (!rst_oe_n) t = "R2 reset release";
        else if (!m_ceo)    t = "R4 handoff release";
        else                t = "R1 drive enable";
        check(t, int'(data_oe), int'(e_oe));
        if (e_oe) check("R3 stream bit", int'(data_o), int'(m_dq));
        check("R4 chain enable", int'(chain_en_n), int'(m_ceo));
        check("R6 R7 cf pulse", int'(cf_drive_low), int'(m_cf != 0));
    endtask

    // {por_n, rst_oe_n, ce_n, cfg_cmd, cycles}
    typedef struct packed {
        logic p; logic r; logic c; logic cmd; logic [7:0] n;
    } vec_t;
    localparam vec_t VECS [12] = '{
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'd3},   // R8 power-on reset
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'd2},   // R2 held in stream reset
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'd20},  // R1 R3 first 20 bits
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'd5},   // R5 standby, counter holds
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'd45},  // R1 R4 resume and hand off
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'd2},   // R2 R4 reset clears handoff
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'd1},   // R6 command while streaming
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'd2},
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'd3},   // R7 command during pulse
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'd70},  // R4 full stream and handoff
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'd3},   // R4 handoff held in standby
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'd2}    // R8 power-on reset after handoff
    };

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        foreach (VECS[i]) begin
            for (int k = 0; k < int'(VECS[i].n); k++)
                tick(VECS[i].p, VECS[i].r, VECS[i].c, VECS[i].cmd);
        end

        // R8: reset state seen at the ports
        tick(1'b0, 1'b1, 1'b0, 1'b0);
        check("R8 reset oe", int'(data_oe), 0);
        check("R8 reset chain", int'(chain_en_n), 1);
        check("R8 reset cf", int'(cf_drive_low), 0);

        // R6: measure pulse width directly
        begin
            int w = 0;
            tick(1'b1, 1'b1, 1'b1, 1'b1);
            for (int k = 0; k < 10; k++) begin
                if (cf_drive_low) w++;
                tick(1'b1, 1'b1, 1'b1, 1'b0);
            end
            check("R6 pulse width", w, CF_WIDTH);
        end

        // R7: command held high through the pulse gives one pulse of CF_WIDTH
        begin
            int w = 0;
            for (int k = 0; k < CF_WIDTH; k++) begin
                tick(1'b1, 1'b1, 1'b1, 1'b1);
                if (cf_drive_low) w++;
            end
            check("R7 no extension", w, CF_WIDTH);
            tick(1'b1, 1'b1, 1'b1, 1'b0);
            check("R7 pulse ended", int'(cf_drive_low), 0);
        end

        // R2: mid-stream reset restarts at bit 0
        for (int k = 0; k < 13; k++) tick(1'b1, 1'b1, 1'b0, 1'b0);
        tick(1'b1, 1'b0, 1'b0, 1'b0);
        tick(1'b1, 1'b1, 1'b0, 1'b0);
        check("R2 restart bit0", int'(data_o), int'(exp_bit(0)));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule